// File: doc/BRIEF.md
# Conditional Execution Gate and Decode Indexer

This block is one registered front-end stage that sits between instruction fetch and decode. Each cycle in which `in_valid` is high it takes a fetched instruction word, a state bit that says whether the word is a full 32-bit instruction or a 16-bit compact one, the four arithmetic flags and the current program counter. One cycle later it presents three things. The first is an execute enable. The second is the row number into an external decode table. The third is the cycle charge that a skipped instruction still costs, because its prefetch slot was spent anyway.

For a 32-bit instruction, the top four bits carry a condition code. The block tests that code against the flags. If the test fails, the execute enable is low and the fixed prefetch charge appears on the charge output. Two disjoint opcode fields are packed into a 12-bit table row. A compact instruction always executes. Its 10-bit row comes straight from one opcode field and is zero-extended onto the same row port. The stage also returns the fetch address, which is the PC minus one instruction width, and the PC advanced by that width.

The decode table itself and the execution units live outside this block. So does the cycle accumulator that adds up the charges.

Top module: `cond_gate_stage`

## Requirements
- R1: Condition codes 4'hE and 4'hF on `in_opcode[31:28]` make a 32-bit instruction execute whatever the flags hold.
- R2: Codes 4'h0 to 4'h7 each test one flag. `in_flags` is {N,Z,C,V} with N at bit 3 and V at bit 0. The tests are: 0 is Z set, 1 is Z clear, 2 is C set, 3 is C clear, 4 is N set, 5 is N clear, 6 is V set, 7 is V clear.
- R3: Codes 4'h8 to 4'hD combine flags. The tests are: 8 is C & ~Z, 9 is ~C | Z, A is N==V, B is N!=V, C is ~Z & (N==V), D is Z | (N!=V).
- R4: A 32-bit instruction whose condition fails gives `out_exec`=0 and `out_charge`=PREFETCH_CHARGE (default 1). Every instruction that executes gives `out_charge`=0.
- R5: For a 32-bit instruction, `out_index` is {`in_opcode[27:20]`, `in_opcode[7:4]`}. No other opcode bit affects it.
- R6: For a compact instruction (`in_compact`=1), `out_index` is {2'b00, `in_opcode[15:6]`} and `out_exec`=1. The condition bits and the flags have no effect.
- R7: `out_fetch_addr` is `in_pc` minus the instruction width and `out_next_pc` is `in_pc` plus that width. The width is 4 for 32-bit instructions and 2 for compact ones. Both wrap modulo 2^PC_W.
- R8: The outputs register the inputs seen at a clock edge where `in_valid`=1. They appear one cycle later with `out_valid`=1. After an edge with `in_valid`=0, `out_valid` is 0 and every other output holds its value.
- R9: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_compact | input | 1 | 1 = 16-bit compact instruction, 0 = 32-bit instruction |
| in_opcode | input | OPC_W | Fetched instruction word (compact word in the low 16 bits) |
| in_flags | input | 4 | Flags {N,Z,C,V} |
| in_pc | input | PC_W | Current program counter |
| out_valid | output | 1 | Registered result is new this cycle |
| out_exec | output | 1 | Instruction executes |
| out_index | output | 12 | Decode table row |
| out_charge | output | CHARGE_W | Cycle charge for a skipped instruction |
| out_fetch_addr | output | PC_W | Address the instruction was fetched from |
| out_next_pc | output | PC_W | Program counter after the step |

## Verification
The bound checker watches several properties on every cycle:
- the charge is consistent with the execute enable;
- a compact instruction always executes, with the top row bits clear;
- the always-execute codes, a failed equality test and a true signed-less-than test;
- the 32-bit row packing and the PC step for both widths;
- the one-cycle result pulse and the hold when no instruction is presented.

Some behaviour can only be shown by the bench's scenarios. These are the full truth table of all sixteen codes against chosen flag patterns, the proof that untouched opcode bits never reach the row, address wrap at PC zero, and the all-zero outputs during reset.

// File: rtl/cond_gate_pkg.sv
package cond_gate_pkg;

   // Field positions the decode table depends on
   localparam int COND_MSB   = 31;
   localparam int COND_LSB   = 28;
   localparam int WHI_MSB    = 27;
   localparam int WHI_LSB    = 20;
   localparam int WLO_MSB    = 7;
   localparam int WLO_LSB    = 4;
   localparam int NAR_MSB    = 15;
   localparam int NAR_LSB    = 6;
   localparam int WHI_W      = WHI_MSB - WHI_LSB + 1;
   localparam int WLO_W      = WLO_MSB - WLO_LSB + 1;
   localparam int NAR_W      = NAR_MSB - NAR_LSB + 1;
   localparam int IDX_W      = WHI_W + WLO_W;
   localparam int COND_W     = COND_MSB - COND_LSB + 1;
   localparam int NUM_CODES  = 1 << COND_W;

   typedef enum logic [COND_W-1:0] {
      CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
      CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
      CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
      CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_XX = 4'hF
   } cond_code_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } flags_t;

   function automatic logic cond_holds(input cond_code_e code, input flags_t f);
      logic r;
      case (code)
         CC_EQ:   r = f.z;
         CC_NE:   r = ~f.z;
         CC_CS:   r = f.c;
         CC_CC:   r = ~f.c;
         CC_MI:   r = f.n;
         CC_PL:   r = ~f.n;
         CC_VS:   r = f.v;
         CC_VC:   r = ~f.v;
         CC_HI:   r = f.c & ~f.z;
         CC_LS:   r = ~f.c | f.z;
         CC_GE:   r = (f.n == f.v);
         CC_LT:   r = (f.n != f.v);
         CC_GT:   r = ~f.z & (f.n == f.v);
         CC_LE:   r = f.z | (f.n != f.v);
         default: r = 1'b1;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/cg_cond_eval.sv
module cg_cond_eval
   import cond_gate_pkg::*;
(
   input  logic [COND_W-1:0] cond_i,
   input  flags_t            flags_i,
   output logic              pass_o
);

   logic [NUM_CODES-1:0] pass_vec;

   // One evaluator per code; the code field then selects one result
   for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
      assign pass_vec[i] = cond_holds(cond_code_e'(COND_W'(i)), flags_i);
   end

   assign pass_o = pass_vec[cond_i];

endmodule

// File: rtl/cg_index_former.sv
module cg_index_former
   import cond_gate_pkg::*;
(
   input  logic             compact_i,
   input  logic [WHI_W-1:0] wide_hi_i,
   input  logic [WLO_W-1:0] wide_lo_i,
   input  logic [NAR_W-1:0] narrow_i,
   output logic [IDX_W-1:0] index_o
);

   localparam int PAD_W = IDX_W - NAR_W;

   logic [IDX_W-1:0] wide_idx;
   logic [IDX_W-1:0] narrow_idx;

   assign wide_idx = {wide_hi_i, wide_lo_i};

   if (PAD_W > 0) begin : g_pad
      assign narrow_idx = {{PAD_W{1'b0}}, narrow_i};
   end else begin : g_nopad
      assign narrow_idx = narrow_i[IDX_W-1:0];
   end

   assign index_o = compact_i ? narrow_idx : wide_idx;

endmodule

// File: rtl/cg_pc_stepper.sv
module cg_pc_stepper #(
   parameter int PC_W         = 32,
   parameter int WIDE_BYTES   = 4,
   parameter int NARROW_BYTES = 2
) (
   input  logic            compact_i,
   input  logic [PC_W-1:0] pc_i,
   output logic [PC_W-1:0] fetch_o,
   output logic [PC_W-1:0] next_o
);

   localparam logic [PC_W-1:0] WIDE_STEP   = PC_W'(WIDE_BYTES);
   localparam logic [PC_W-1:0] NARROW_STEP = PC_W'(NARROW_BYTES);

   logic [PC_W-1:0] step;

   assign step    = compact_i ? NARROW_STEP : WIDE_STEP;
   assign fetch_o = pc_i - step;
   assign next_o  = pc_i + step;

endmodule

// File: rtl/cond_gate_stage.sv
module cond_gate_stage
   import cond_gate_pkg::*;
#(
   parameter int OPC_W           = 32,
   parameter int PC_W            = 32,
   parameter int CHARGE_W        = 3,
   parameter int PREFETCH_CHARGE = 1,
   parameter int WIDE_BYTES      = 4,
   parameter int NARROW_BYTES    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic                in_compact,
   input  logic [OPC_W-1:0]    in_opcode,
   input  logic [3:0]          in_flags,
   input  logic [PC_W-1:0]     in_pc,
   output logic                out_valid,
   output logic                out_exec,
   output logic [IDX_W-1:0]    out_index,
   output logic [CHARGE_W-1:0] out_charge,
   output logic [PC_W-1:0]     out_fetch_addr,
   output logic [PC_W-1:0]     out_next_pc
);

   localparam logic [CHARGE_W-1:0] SKIP_COST = CHARGE_W'(PREFETCH_CHARGE);

   // Elaboration-time parameter checks
   if (OPC_W != 32) begin : g_bad_opc
      $error("cond_gate_stage: OPC_W must be 32");
   end
   if (PREFETCH_CHARGE < 1 || PREFETCH_CHARGE >= (1 << CHARGE_W)) begin : g_bad_charge
      $error("cond_gate_stage: PREFETCH_CHARGE does not fit CHARGE_W");
   end
   if (NARROW_BYTES < 1 || WIDE_BYTES <= NARROW_BYTES) begin : g_bad_width
      $error("cond_gate_stage: instruction widths inconsistent");
   end
   if (PC_W < 8) begin : g_bad_pc
      $error("cond_gate_stage: PC_W too small");
   end

   logic                cond_pass;
   logic                exec_d;
   logic [IDX_W-1:0]    index_d;
   logic [CHARGE_W-1:0] charge_d;
   logic [PC_W-1:0]     fetch_d;
   logic [PC_W-1:0]     next_d;
   logic                unused_opc_bits;

   assign unused_opc_bits = ^{in_opcode[WHI_LSB-1:NAR_MSB+1], in_opcode[WLO_LSB-1:0]};

   cg_cond_eval u_cond (
      .cond_i  (in_opcode[COND_MSB:COND_LSB]),
      .flags_i (flags_t'(in_flags)),
      .pass_o  (cond_pass)
   );

   cg_index_former u_index (
      .compact_i (in_compact),
      .wide_hi_i (in_opcode[WHI_MSB:WHI_LSB]),
      .wide_lo_i (in_opcode[WLO_MSB:WLO_LSB]),
      .narrow_i  (in_opcode[NAR_MSB:NAR_LSB]),
      .index_o   (index_d)
   );

   cg_pc_stepper #(
      .PC_W         (PC_W),
      .WIDE_BYTES   (WIDE_BYTES),
      .NARROW_BYTES (NARROW_BYTES)
   ) u_pc (
      .compact_i (in_compact),
      .pc_i      (in_pc),
      .fetch_o   (fetch_d),
      .next_o    (next_d)
   );

   assign exec_d   = in_compact | cond_pass;
   assign charge_d = exec_d ? '0 : SKIP_COST;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid      <= 1'b0;
         out_exec       <= 1'b0;
         out_index      <= '0;
         out_charge     <= '0;
         out_fetch_addr <= '0;
         out_next_pc    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_exec       <= exec_d;
            out_index      <= index_d;
            out_charge     <= charge_d;
            out_fetch_addr <= fetch_d;
            out_next_pc    <= next_d;
         end
      end
   end

endmodule

// File: rtl/cond_gate_chk.sv
module cond_gate_chk
   import cond_gate_pkg::*;
#(
   parameter int OPC_W           = 32,
   parameter int PC_W            = 32,
   parameter int CHARGE_W        = 3,
   parameter int PREFETCH_CHARGE = 1,
   parameter int WIDE_BYTES      = 4,
   parameter int NARROW_BYTES    = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_compact,
   input logic [OPC_W-1:0]    in_opcode,
   input logic [3:0]          in_flags,
   input logic [PC_W-1:0]     in_pc,
   input logic                out_valid,
   input logic                out_exec,
   input logic [IDX_W-1:0]    out_index,
   input logic [CHARGE_W-1:0] out_charge,
   input logic [PC_W-1:0]     out_fetch_addr,
   input logic [PC_W-1:0]     out_next_pc
);

   logic wide_in;
   assign wide_in = in_valid && !in_compact;

   AST_ALWAYS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
      wide_in && (in_opcode[31:29] == 3'b111) |=> out_exec); // R1

   AST_EQ_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      wide_in && (in_opcode[31:28] == 4'h0) && !in_flags[2] |=> !out_exec); // R2

   AST_LT_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
      wide_in && (in_opcode[31:28] == 4'hB) && (in_flags[3] != in_flags[0]) |=> out_exec); // R3

   AST_SKIP_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_exec |-> out_charge == CHARGE_W'(PREFETCH_CHARGE)); // R4

   AST_RUN_NO_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_exec |-> out_charge == '0); // R4

   AST_WIDE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      wide_in |=> out_index == {$past(in_opcode[27:20]), $past(in_opcode[7:4])}); // R5

   AST_COMPACT_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_compact |=> out_exec && (out_index[IDX_W-1:IDX_W-2] == 2'b00)); // R6

   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_next_pc == $past(in_pc)
                   + ($past(in_compact) ? PC_W'(NARROW_BYTES) : PC_W'(WIDE_BYTES))); // R7

   AST_PC_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      wide_in |=> (out_next_pc - out_fetch_addr) == PC_W'(2 * WIDE_BYTES)); // R7

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R8

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && $stable(out_index) && $stable(out_exec)); // R8

endmodule

bind cond_gate_stage cond_gate_chk #(
   .OPC_W           (OPC_W),
   .PC_W            (PC_W),
   .CHARGE_W        (CHARGE_W),
   .PREFETCH_CHARGE (PREFETCH_CHARGE),
   .WIDE_BYTES      (WIDE_BYTES),
   .NARROW_BYTES    (NARROW_BYTES)
) chk_i (.*);

// File: tb/cond_gate_stage_tb_top.sv
`timescale 1ns/1ps
module cond_gate_stage_tb_top;

   localparam int EXP_SKIP = 1;   // R4 default prefetch charge

   typedef struct packed {
      logic [3:0]  req;
      logic        compact;
      logic [3:0]  flags;    // {N,Z,C,V}
      logic [31:0] op;
      logic        exp_exec;
      logic [11:0] exp_idx;
      logic [31:0] pc;
   } vec_t;

   localparam int NV = 30;
   localparam vec_t VECS [NV] = '{
      '{4'd2, 1'b0, 4'b0100, 32'h0A500030, 1'b1, 12'hA53, 32'h00001000}, // R2 EQ pass
      '{4'd2, 1'b0, 4'b0000, 32'h0A500030, 1'b0, 12'hA53, 32'h00001000}, // R2 EQ fail
      '{4'd2, 1'b0, 4'b0000, 32'h1A500030, 1'b1, 12'hA53, 32'h00002000}, // R2 NE
      '{4'd2, 1'b0, 4'b0010, 32'h2A500030, 1'b1, 12'hA53, 32'h00002004}, // R2 CS
      '{4'd2, 1'b0, 4'b0010, 32'h3A500030, 1'b0, 12'hA53, 32'h00002008}, // R2 CC fail
      '{4'd2, 1'b0, 4'b1000, 32'h4A500030, 1'b1, 12'hA53, 32'h0000200C}, // R2 MI
      '{4'd2, 1'b0, 4'b1000, 32'h5A500030, 1'b0, 12'hA53, 32'h00002010}, // R2 PL fail
      '{4'd2, 1'b0, 4'b0001, 32'h6A500030, 1'b1, 12'hA53, 32'h00002014}, // R2 VS
      '{4'd2, 1'b0, 4'b0001, 32'h7A500030, 1'b0, 12'hA53, 32'h00002018}, // R2 VC fail
      '{4'd3, 1'b0, 4'b0010, 32'h8A500030, 1'b1, 12'hA53, 32'h00003000}, // R3 HI
      '{4'd3, 1'b0, 4'b0110, 32'h8A500030, 1'b0, 12'hA53, 32'h00003000}, // R3 HI fail
      '{4'd3, 1'b0, 4'b0110, 32'h9A500030, 1'b1, 12'hA53, 32'h00003004}, // R3 LS
      '{4'd3, 1'b0, 4'b0010, 32'h9A500030, 1'b0, 12'hA53, 32'h00003004}, // R3 LS fail
      '{4'd3, 1'b0, 4'b1001, 32'hAA500030, 1'b1, 12'hA53, 32'h00003008}, // R3 GE
      '{4'd3, 1'b0, 4'b1000, 32'hAA500030, 1'b0, 12'hA53, 32'h00003008}, // R3 GE fail
      '{4'd3, 1'b0, 4'b1000, 32'hBA500030, 1'b1, 12'hA53, 32'h0000300C}, // R3 LT
      '{4'd3, 1'b0, 4'b0000, 32'hBA500030, 1'b0, 12'hA53, 32'h0000300C}, // R3 LT fail
      '{4'd3, 1'b0, 4'b0000, 32'hCA500030, 1'b1, 12'hA53, 32'h00003010}, // R3 GT
      '{4'd3, 1'b0, 4'b0100, 32'hCA500030, 1'b0, 12'hA53, 32'h00003010}, // R3 GT fail on Z
      '{4'd3, 1'b0, 4'b0001, 32'hCA500030, 1'b0, 12'hA53, 32'h00003010}, // R3 GT fail on N!=V
      '{4'd3, 1'b0, 4'b0001, 32'hDA500030, 1'b1, 12'hA53, 32'h00003014}, // R3 LE
      '{4'd3, 1'b0, 4'b0000, 32'hDA500030, 1'b0, 12'hA53, 32'h00003014}, // R3 LE fail
      '{4'd1, 1'b0, 4'b0000, 32'hEA500030, 1'b1, 12'hA53, 32'h00004000}, // R1 always
      '{4'd1, 1'b0, 4'b1111, 32'hEA500030, 1'b1, 12'hA53, 32'h00004000}, // R1 always, all flags
      '{4'd1, 1'b0, 4'b0000, 32'hFA500030, 1'b1, 12'hA53, 32'h00004004}, // R1 code F executes
      '{4'd5, 1'b0, 4'b0000, 32'hEFF000F0, 1'b1, 12'hFFF, 32'h00000000}, // R5 all-ones fields, pc wrap
      '{4'd5, 1'b0, 4'b0000, 32'hE00FFF0F, 1'b1, 12'h000, 32'h00000100}, // R5 other bits ignored
      '{4'd6, 1'b1, 4'b0000, 32'h0000ABCD, 1'b1, 12'h2AF, 32'h00000002}, // R6 compact, EQ bits would fail
      '{4'd6, 1'b1, 4'b0100, 32'hFFFF003F, 1'b1, 12'h000, 32'h00000000}, // R6 compact zero field, pc wrap
      '{4'd6, 1'b1, 4'b0100, 32'h1234FFC0, 1'b1, 12'h3FF, 32'h00008000}  // R6 compact, NE bits would fail
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_compact = 1'b0;
   logic [31:0] in_opcode = '0;
   logic [3:0]  in_flags = '0;
   logic [31:0] in_pc = '0;
   logic        out_valid;
   logic        out_exec;
   logic [11:0] out_index;
   logic [2:0]  out_charge;
   logic [31:0] out_fetch_addr;
   logic [31:0] out_next_pc;

   int checks = 0;
   int errors = 0;
   logic done = 1'b0;

   always #2 clk = ~clk;

   cond_gate_stage dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .in_valid       (in_valid),
      .in_compact     (in_compact),
      .in_opcode      (in_opcode),
      .in_flags       (in_flags),
      .in_pc          (in_pc),
      .out_valid      (out_valid),
      .out_exec       (out_exec),
      .out_index      (out_index),
      .out_charge     (out_charge),
      .out_fetch_addr (out_fetch_addr),
      .out_next_pc    (out_next_pc)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic check_zero(input string req);
      chk(req, "out_valid", 32'(out_valid), 32'h0);
      chk(req, "out_exec", 32'(out_exec), 32'h0);
      chk(req, "out_index", 32'(out_index), 32'h0);
      chk(req, "out_charge", 32'(out_charge), 32'h0);
      chk(req, "out_fetch_addr", out_fetch_addr, 32'h0);
      chk(req, "out_next_pc", out_next_pc, 32'h0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      string tag;
      logic [11:0] held_idx;
      logic        held_exec;

      // R9: outputs zero under reset
      repeat (3) @(negedge clk);
      check_zero("R9");
      @(negedge clk) rst_n = 1'b1;

      // Vector table: drive at a falling edge, sample one falling edge later
      for (int i = 0; i < NV; i++) begin
         tag = $sformatf("R%0d", VECS[i].req);
         in_valid   = 1'b1;
         in_compact = VECS[i].compact;
         in_flags   = VECS[i].flags;
         in_opcode  = VECS[i].op;
         in_pc      = VECS[i].pc;
         @(negedge clk);
         chk("R8", "out_valid", 32'(out_valid), 32'h1);
         chk(tag, "out_exec", 32'(out_exec), 32'(VECS[i].exp_exec));
         chk(VECS[i].compact ? "R6" : "R5", "out_index", 32'(out_index), 32'(VECS[i].exp_idx));
         chk("R4", "out_charge", 32'(out_charge), VECS[i].exp_exec ? 32'h0 : 32'(EXP_SKIP));
         chk("R7", "out_fetch_addr", out_fetch_addr,
             VECS[i].pc - (VECS[i].compact ? 32'd2 : 32'd4));
         chk("R7", "out_next_pc", out_next_pc,
             VECS[i].pc + (VECS[i].compact ? 32'd2 : 32'd4));
      end

      // R8: idle input leaves outputs held, out_valid drops
      held_idx   = out_index;
      held_exec  = out_exec;
      in_valid   = 1'b0;
      in_compact = 1'b0;
      in_opcode  = 32'h0F0FF0F0;
      in_flags   = 4'b0000;
      @(negedge clk);
      chk("R8", "idle out_valid", 32'(out_valid), 32'h0);
      chk("R8", "idle out_index held", 32'(out_index), 32'(held_idx));
      chk("R8", "idle out_exec held", 32'(out_exec), 32'(held_exec));
      @(negedge clk);
      chk("R8", "second idle out_index", 32'(out_index), 32'(held_idx));

      // R4: skipped instruction, then back-to-back executed one clears the charge
      in_valid  = 1'b1;
      in_opcode = 32'h1A500030;   // NE with Z set: fails
      in_flags  = 4'b0100;
      in_pc     = 32'h00005000;
      @(negedge clk);
      chk("R4", "skip exec", 32'(out_exec), 32'h0);
      chk("R4", "skip charge", 32'(out_charge), 32'(EXP_SKIP));
      in_opcode = 32'h0A500030;   // EQ with Z set: passes
      @(negedge clk);
      chk("R4", "run exec", 32'(out_exec), 32'h1);
      chk("R4", "run charge", 32'(out_charge), 32'h0);
      in_valid = 1'b0;
      @(negedge clk);

      // R9: reset in mid-run clears everything
      rst_n = 1'b0;
      @(negedge clk);
      check_zero("R9");
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule